// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block brings a wedged I2C bus back to idle on behalf of a master. When asked, it releases both lines for one half-period and then samples them. A low SCL cannot be cured from the master side, so the block reports straight away that a hardware reset is needed. If SDA is high, the bus is only in an unknown state, so the block skips clocking and issues a STOP. If SDA is low, some device is holding it mid-byte. The block then clocks SCL, up to nine times, and samples SDA near the end of every high phase. As soon as SDA reads high it finishes with a STOP.

An optional mode places a START condition inside every recovery pulse whose high phase shows SDA released. In that mode the block always runs the full nine pulses and then ends with a STOP. Both lines are open-drain: an output enable pulls the line low. The line states come back through a two-flop synchronizer. A half-period setting, captured at the request, sets every SCL phase length.

Top module: `i2c_bus_recover`

## Requirements
- R1: During and after reset, scl_oe, sda_oe, busy, done, success and hw_reset_needed are 0 and pulse_count is 0.
- R2: A request seen while idle is accepted at that clock edge. busy is 1 from the next cycle. Both lines are then released for one phase. One phase is H cycles, where H is the captured half_period raised to at least 4. pulse_count is cleared to 0 on acceptance.
- R3: If SCL reads low at the end of that first phase, the run ends at once with hw_reset_needed=1, success=0, pulse_count=0, and no line ever pulled.
- R4: If SDA reads high at the end of the first phase, no SCL pulse is made. The STOP runs four phases of H cycles each, with (scl_oe,sda_oe) = (1,0), (1,1), (0,1), (0,0). No cycle ever changes both enables together.
- R5: A recovery pulse is one phase with scl_oe=1, then one phase with SCL released. pulse_count rises by one at the first cycle of each high phase. SDA is judged on the last cycle of that high phase.
- R6: With start_mode=0, the first pulse that judges SDA high is the last pulse, and the four-phase STOP of R4 follows it.
- R7: At most nine pulses are made. If SDA is still low at the ninth, the run ends with hw_reset_needed=1, success=0, pulse_count=9.
- R8: With start_mode=1, every pulse that judges SDA high is followed by a START phase of H cycles (SCL released, sda_oe=1). Unless this is the ninth pulse, a hold phase of H cycles with both enables at 1 comes next. Pulses continue to nine. After a START at the ninth pulse, the phases (1,1), (0,1), (0,0) follow.
- R9: If SDA reads high on the last cycle of the final STOP phase, the run ends with success=1 and hw_reset_needed=0.
- R10: done is 1 for exactly the first cycle in which busy is 0 after a run. success, hw_reset_needed and pulse_count then hold until the next accepted request.
- R11: A request while busy is ignored: the run in progress continues cycle for cycle unchanged.
- R12: half_period and start_mode are captured at acceptance. Changing them during a run has no effect. A half_period below 4 acts as 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| recover_req | input | 1 | Request a recovery run |
| start_mode | input | 1 | 1: insert a START inside each pulse that sees SDA high |
| half_period | input | DIV_W | SCL half-period in clock cycles (minimum 4 applied) |
| scl_in | input | 1 | Sensed SCL line level |
| sda_in | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run strobe |
| success | output | 1 | Last run freed the bus |
| hw_reset_needed | output | 1 | Last run failed; bus needs a hardware reset |
| pulse_count | output | CNT_W | Recovery pulses made in the current or last run |

## Verification
Every result is tied to the acceptance edge. The line enables and busy change on the edge that accepts or ends a phase. Each phase then lasts exactly H cycles, and the probe decision falls H cycles after acceptance. done appears in the cycle after the last phase. The bench expands each scenario into a per-cycle queue of expected enables, flags and pulse count. It builds this from the phase lengths above and from a device model that lets SDA go after a set number of SCL rises. It then compares the queue with the outputs 1 ns after every rising edge, so each result is checked in the cycle it is due, no earlier and no later.

// File: rtl/i2c_rcv_pkg.sv
`timescale 1ns/1ps
package i2c_rcv_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PROBE,
    ST_CLK_LO,
    ST_CLK_HI,
    ST_START,
    ST_START_HOLD,
    ST_STOP_PREP,
    ST_STOP_LO,
    ST_STOP_HI,
    ST_STOP_REL
  } rcv_state_t;

  // States in which the engine pulls SCL low.
  function automatic logic pulls_scl(rcv_state_t s);
    return (s == ST_CLK_LO) || (s == ST_START_HOLD) ||
           (s == ST_STOP_PREP) || (s == ST_STOP_LO);
  endfunction

  // States in which the engine pulls SDA low.
  function automatic logic pulls_sda(rcv_state_t s);
    return (s == ST_START) || (s == ST_START_HOLD) ||
           (s == ST_STOP_LO) || (s == ST_STOP_HI);
  endfunction

  // Phase length actually used: requested value with a floor applied.
  function automatic int unsigned eff_half(int unsigned req, int unsigned floor_v);
    return (req < floor_v) ? floor_v : req;
  endfunction

endpackage

// File: rtl/i2c_rcv_sync.sv
`timescale 1ns/1ps
module i2c_rcv_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  generate
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;   // released lines read high
        else        chain_q <= {chain_q[STAGES-2:0], d[b]};
      end
      assign q[b] = chain_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/i2c_rcv_timer.sv
`timescale 1ns/1ps
module i2c_rcv_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] load_val,
  output logic             expire
);

  logic [DIV_W-1:0] tmr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            tmr_q <= '0;
    else if (load)         tmr_q <= load_val - 1'b1;
    else if (tmr_q != '0)  tmr_q <= tmr_q - 1'b1;
  end

  assign expire = (tmr_q == '0);

  // Each phase starts with the full count so it lasts load_val cycles.
  assert_phase_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (tmr_q == $past(load_val) - 1'b1));

endmodule

// File: rtl/i2c_rcv_seq.sv
`timescale 1ns/1ps
module i2c_rcv_seq
  import i2c_rcv_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int MAX_PULSES = 9,
  parameter int MIN_HALF   = 4,
  parameter int CNT_W      = $clog2(MAX_PULSES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             recover_req,
  input  logic             start_mode,
  input  logic [DIV_W-1:0] half_period,
  input  logic             scl_s,
  input  logic             sda_s,
  input  logic             expire,
  output logic             load,
  output logic [DIV_W-1:0] load_val,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic             busy,
  output logic             done,
  output logic             success,
  output logic             hw_reset_needed,
  output logic [CNT_W-1:0] pulse_count
);

  localparam logic [CNT_W-1:0] LAST_PULSE = CNT_W'(MAX_PULSES);

  rcv_state_t       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] half_q;
  logic             mode_q;
  logic             scl_oe_q, sda_oe_q, done_q, success_q, hw_q;

  // Named internal events, used by the sequencing and the assertions.
  logic accept, phase_end, last_pulse, finish_ok, finish_bad;
  logic in_start, stop_release;
  logic [DIV_W-1:0] req_half;

  assign accept       = (state_q == ST_IDLE) && recover_req;
  assign phase_end    = (state_q != ST_IDLE) && expire;
  assign last_pulse   = (cnt_q == LAST_PULSE);
  assign in_start     = (state_q == ST_START);
  assign stop_release = (state_q == ST_STOP_REL);
  assign req_half     = DIV_W'(eff_half(int'(half_period), MIN_HALF));

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    finish_ok  = 1'b0;
    finish_bad = 1'b0;
    if (accept) begin
      state_d = ST_PROBE;
      cnt_d   = '0;
    end else if (phase_end) begin
      case (state_q)
        ST_PROBE: begin
          if (!scl_s) begin
            state_d    = ST_IDLE;
            finish_bad = 1'b1;
          end else if (sda_s) begin
            state_d = ST_STOP_PREP;
          end else begin
            state_d = ST_CLK_LO;
          end
        end
        ST_CLK_LO: begin
          state_d = ST_CLK_HI;
          cnt_d   = cnt_q + 1'b1;
        end
        ST_CLK_HI: begin
          if (sda_s) begin
            state_d = mode_q ? ST_START : ST_STOP_PREP;
          end else if (last_pulse) begin
            state_d    = ST_IDLE;
            finish_bad = 1'b1;
          end else begin
            state_d = ST_CLK_LO;
          end
        end
        ST_START:      state_d = last_pulse ? ST_STOP_LO : ST_START_HOLD;
        ST_START_HOLD: state_d = ST_CLK_LO;
        ST_STOP_PREP:  state_d = ST_STOP_LO;
        ST_STOP_LO:    state_d = ST_STOP_HI;
        ST_STOP_HI:    state_d = ST_STOP_REL;
        ST_STOP_REL: begin
          state_d    = ST_IDLE;
          finish_ok  = sda_s;
          finish_bad = !sda_s;
        end
        default:       state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      half_q    <= DIV_W'(MIN_HALF);
      mode_q    <= 1'b0;
      scl_oe_q  <= 1'b0;
      sda_oe_q  <= 1'b0;
      done_q    <= 1'b0;
      success_q <= 1'b0;
      hw_q      <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      scl_oe_q <= pulls_scl(state_d);
      sda_oe_q <= pulls_sda(state_d);
      done_q   <= finish_ok || finish_bad;
      if (accept) begin
        half_q    <= req_half;
        mode_q    <= start_mode;
        success_q <= 1'b0;
        hw_q      <= 1'b0;
      end else begin
        if (finish_ok)  success_q <= 1'b1;
        if (finish_bad) hw_q      <= 1'b1;
      end
    end
  end

  assign load            = accept || phase_end;
  assign load_val        = accept ? req_half : half_q;
  assign scl_oe          = scl_oe_q;
  assign sda_oe          = sda_oe_q;
  assign busy            = (state_q != ST_IDLE);
  assign done            = done_q;
  assign success         = success_q;
  assign hw_reset_needed = hw_q;
  assign pulse_count     = cnt_q;

  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && !sda_oe));

  assert_one_line_moves_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !((scl_oe != $past(scl_oe)) && (sda_oe != $past(sda_oe))));

  assert_stop_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sda_oe) && !scl_oe) |-> stop_release);

  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |->
      ((pulse_count == $past(pulse_count)) || (pulse_count == $past(pulse_count) + 1'b1)));

  assert_pulse_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_count <= LAST_PULSE);

  assert_start_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) && !scl_oe) |-> in_start);

  assert_outcome_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(success && hw_reset_needed));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/i2c_bus_recover.sv
`timescale 1ns/1ps
module i2c_bus_recover #(
  parameter int DIV_W      = 8,
  parameter int MAX_PULSES = 9,
  parameter int MIN_HALF   = 4,
  parameter int CNT_W      = $clog2(MAX_PULSES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             recover_req,
  input  logic             start_mode,
  input  logic [DIV_W-1:0] half_period,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic             busy,
  output logic             done,
  output logic             success,
  output logic             hw_reset_needed,
  output logic [CNT_W-1:0] pulse_count
);

  logic             scl_s, sda_s;
  logic             tmr_load, tmr_expire;
  logic [DIV_W-1:0] tmr_val;

  i2c_rcv_sync #(.WIDTH(2), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({scl_in, sda_in}),
    .q     ({scl_s, sda_s})
  );

  i2c_rcv_timer #(.DIV_W(DIV_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expire   (tmr_expire)
  );

  i2c_rcv_seq #(
    .DIV_W      (DIV_W),
    .MAX_PULSES (MAX_PULSES),
    .MIN_HALF   (MIN_HALF),
    .CNT_W      (CNT_W)
  ) u_seq (
    .clk             (clk),
    .rst_n           (rst_n),
    .recover_req     (recover_req),
    .start_mode      (start_mode),
    .half_period     (half_period),
    .scl_s           (scl_s),
    .sda_s           (sda_s),
    .expire          (tmr_expire),
    .load            (tmr_load),
    .load_val        (tmr_val),
    .scl_oe          (scl_oe),
    .sda_oe          (sda_oe),
    .busy            (busy),
    .done            (done),
    .success         (success),
    .hw_reset_needed (hw_reset_needed),
    .pulse_count     (pulse_count)
  );

endmodule

// File: tb/i2c_bus_recover_bench.sv
`timescale 1ns/1ps
module i2c_bus_recover_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0;
  logic       smode = 1'b0;
  logic [7:0] hp = 8'd5;
  logic       scl_stuck = 1'b0;
  logic       scl_oe, sda_oe, busy, done, success, hw_rst;
  logic [3:0] pcount;
  logic       scl_line, sda_line;
  int         rises = 0;
  int         dev_target = 0;

  // Open-drain bus: a device keeps SDA low until dev_target SCL rises seen.
  assign scl_line = !(scl_oe || scl_stuck);
  assign sda_line = !(sda_oe || (rises < dev_target));
  always @(posedge scl_line) rises <= rises + 1;

  always #2.5 clk = ~clk;

  i2c_bus_recover u_i2c_bus_recover (
    .clk (clk), .rst_n (rst_n), .recover_req (req), .start_mode (smode),
    .half_period (hp), .scl_in (scl_line), .sda_in (sda_line),
    .scl_oe (scl_oe), .sda_oe (sda_oe), .busy (busy), .done (done),
    .success (success), .hw_reset_needed (hw_rst), .pulse_count (pcount)
  );

  // Vector layout: {scl_oe, sda_oe, busy, done, success, hw, count[3:0]}
  typedef struct { logic [9:0] v; string tag; } exp_t;
  exp_t       exp_q[$];
  logic [3:0] last_cnt = 4'd0;
  logic       last_ok = 1'b0, last_bad = 1'b0;
  int         n_cmp = 0, n_bad = 0;
  bit         cmp_on = 1'b0, finished = 1'b0;
  int         ph = 4;

  function automatic logic [9:0] actual();
    return {scl_oe, sda_oe, busy, done, success, hw_rst, pcount};
  endfunction

  task automatic check(string tag, logic [9:0] act, logic [9:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  task automatic push(int n, bit s, bit d, int cnt, string tag);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.v = {s, d, 1'b1, 1'b0, 1'b0, 1'b0, 4'(cnt)};
      e.tag = tag;
      exp_q.push_back(e);
    end
  endtask

  task automatic push_end(int cnt, bit ok, string tag);
    exp_t e;
    e.v = {1'b0, 1'b0, 1'b0, 1'b1, ok, !ok, 4'(cnt)};
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Behavioural expansion of one run into per-cycle expectations.
  task automatic plan(int k, bit mode, bit stuck, int h);
    push(h, 0, 0, 0, "R2");
    if (stuck) begin
      push_end(0, 0, "R3");
      return;
    end
    if (k == 0) begin
      push(h, 1, 0, 0, "R4"); push(h, 1, 1, 0, "R4");
      push(h, 0, 1, 0, "R4"); push(h, 0, 0, 0, "R4");
      push_end(0, 1, "R9");
      return;
    end
    for (int p = 1; p <= 9; p++) begin
      bit high = (p >= k);
      push(h, 1, 0, p - 1, "R5");
      push(h, 0, 0, p, "R5");
      if (high && !mode) begin
        push(h, 1, 0, p, "R6"); push(h, 1, 1, p, "R6");
        push(h, 0, 1, p, "R6"); push(h, 0, 0, p, "R6");
        push_end(p, 1, "R9");
        return;
      end
      if (high && mode) begin
        push(h, 0, 1, p, "R8");
        if (p == 9) begin
          push(h, 1, 1, p, "R8"); push(h, 0, 1, p, "R8"); push(h, 0, 0, p, "R8");
          push_end(p, 1, "R9");
          return;
        end
        push(h, 1, 1, p, "R8");
      end
      if (!high && p == 9) begin
        push_end(9, 0, "R7");
        return;
      end
    end
  endtask

  // Compare every cycle, 1 ns after the rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (cmp_on) begin
        exp_t e;
        if (exp_q.size() > 0) begin
          e = exp_q.pop_front();
          if (e.v[6]) begin
            last_cnt = e.v[3:0]; last_ok = e.v[5]; last_bad = e.v[4];
          end
        end else begin
          e.v = {4'b0000, last_ok, last_bad, last_cnt};
          e.tag = "R10";
        end
        check(e.tag, actual(), e.v);
      end
    end
  end

  task automatic run(int k, bit mode, bit stuck, int h_in, int poke, string tag);
    @(negedge clk);
    scl_stuck = stuck;
    repeat (2) @(negedge clk);
    dev_target = rises + k;
    hp = 8'(h_in);
    smode = mode;
    ph = (h_in < 4) ? 4 : h_in;
    repeat (3) @(negedge clk);
    plan(k, mode, stuck, ph);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    if (poke > 0) begin
      repeat (poke) @(negedge clk);
      req = 1'b1;           // R11: request while busy
      hp = 8'd200;          // R12: live changes must not matter
      smode = !mode;
      @(negedge clk);
      req = 1'b0;
    end
    while (exp_q.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
    check(tag, actual(), {4'b0000, last_ok, last_bad, last_cnt});
    hp = 8'(h_in);
    smode = mode;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", actual(), 10'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", actual(), 10'd0);
    cmp_on = 1'b1;
    repeat (4) @(negedge clk);
    run(0, 0, 0, 5, 0, "R4");
    run(3, 0, 0, 4, 0, "R6");
    run(12, 0, 0, 4, 0, "R7");
    run(9, 0, 0, 4, 0, "R6");
    run(2, 1, 0, 4, 0, "R8");
    run(12, 1, 0, 4, 0, "R7");
    run(0, 0, 1, 6, 0, "R3");
    run(1, 0, 0, 1, 0, "R12");
    run(2, 0, 0, 4, 10, "R11");
    run(0, 1, 0, 4, 0, "R9");
    run(4, 1, 0, 7, 0, "R5");
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog t=%0t actual=hung expected=finished", $time);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule